// File: doc/BRIEF.md
# Audio Interface Status and Interrupt Controller

This block holds the control word and the status word of a digital audio serial interface, together with the single interrupt line that goes with them. The receiver, the transmitter and four FIFOs (transmit data, receive data, transmit user, receive user) send it event pulses and level signals. From these it keeps three kinds of status flag:

- sticky event flags, which stay set until software clears them;
- live FIFO attention flags;
- four busy flags, which follow enable, lock and frame-end timing.

Each interrupt source in the status word has an enable bit at the same position in the control word. The interrupt line is the registered OR of every enabled source.

Software uses a simple write port. A write with `wr_sel` low replaces the control word. A write with `wr_sel` high goes to the status word and clears each sticky flag whose data bit is one. Both words are always visible on read-back outputs. The serial line coding and the FIFO storage sit outside this block.

Top module: `aud_stat_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, `ctrl_rd`, `stat_rd` and `irq` are all zero.
- R2: A pulse on `evt_in[k]` sets status bit 20+k on the next clock, and the bit stays set until it is cleared. The event map is: k=0 valid user unit, k=1 full channel-status block, k=2 B preamble, k=3 bad or missing preamble, k=4 receive FIFO overrun, k=5 transmit FIFO underrun.
- R3: A status write (`wr_sel`=1) clears each sticky bit 25..20 whose `wr_data` bit is one. Bits written with zero keep their value.
- R4: When an event and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R5: Status bits 19..16 show `attn_in[3:0]` one clock later. The map is: bit 19 receive user, bit 18 transmit user, bit 17 receive data, bit 16 transmit data. Status writes have no effect on these bits.
- R6: Transmit busy (status bit 28) is set the clock after control bit 28 (transmit enable) reads one. With the enable clear, the flag stays set until the first `tx_frame_end` pulse, and it falls on that clock.
- R7: Receive busy (status bit 29) is set the clock after an `rx_lock` pulse while control bit 29 (receive enable) is one. It clears on an `rx_frame_end` pulse while the enable is zero. It also clears on an `rx_idle` pulse at any time, and this clear wins over a lock.
- R8: Channel-status busy (status bit 27) is set on a `cs_first_load` pulse while control bits 28 and 27 are both one. It clears on a `cs_last_load` pulse, or on `tx_frame_end` while bit 28 is zero. A clear wins over a set.
- R9: User busy (status bit 26) is set while control bits 28 and 26 are one and `tu_has_data` is one. It clears when `tu_has_data` is zero, or on `tx_frame_end` while bit 28 is zero.
- R10: `irq` equals, one clock later, the OR over bits 25..16 of (`stat_rd` AND `ctrl_rd`).
- R11: A control write (`wr_sel`=0) stores `wr_data` bits 29..16. Control bits 31..30 and 15..0 read zero, and so do status bits 31..30 and 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 writes the control word, 1 clears status bits |
| wr_data | input | 32 | Write data |
| evt_in | input | 6 | Sticky event pulses (map in R2) |
| attn_in | input | 4 | FIFO attention levels (map in R5) |
| rx_lock | input | 1 | Receiver locked onto a preamble |
| rx_idle | input | 1 | Input stream went inactive |
| rx_frame_end | input | 1 | Receive frame boundary |
| tx_frame_end | input | 1 | Transmit frame boundary |
| cs_first_load | input | 1 | First channel-status word loaded into the shifter |
| cs_last_load | input | 1 | Last channel-status word loaded into the shifter |
| tu_has_data | input | 1 | Transmit user FIFO holds data |
| ctrl_rd | output | 32 | Control word read-back |
| stat_rd | output | 32 | Status word read-back |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions check the cycle-level rules on every clock:
- a sticky flag holds when there is neither an event nor a write;
- a write clears only what it names, and an event overrides a clear;
- attention bits mirror their inputs one clock later;
- transmit busy rises after the enable, and receive busy falls on idle;
- user busy drops once the FIFO empties;
- the interrupt line tracks the enabled flags;
- unused bits stay zero.

The bench's scenarios are needed for the longer histories. These include busy flags held across many cycles after an enable drops until the right frame end arrives, channel-status busy across a whole load sequence, and combinations of control writes racing busy updates. A bench-side reference model checks all of these against random and directed stimulus.

// File: rtl/aud_stat_pkg.sv
package aud_stat_pkg;

  typedef struct packed {
    logic rx;
    logic tx;
    logic cs;
    logic usr;
  } busy_t;

  // One sticky bit: a set in the same cycle overrides a clear.
  function automatic logic sticky_bit(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction

  // Busy flag update with a selectable winner when set and clear coincide.
  function automatic logic busy_next(input logic q, input logic set, input logic clr,
                                     input logic set_wins);
    logic r;
    if (set_wins) r = set ? 1'b1 : (clr ? 1'b0 : q);
    else          r = clr ? 1'b0 : (set ? 1'b1 : q);
    return r;
  endfunction

  // Any enabled source present.
  function automatic logic any_enabled(input logic [31:0] flags, input logic [31:0] en);
    return |(flags & en);
  endfunction

endpackage

// File: rtl/aud_sticky_bank.sv
module aud_sticky_bank import aud_stat_pkg::*; #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= sticky_bit(q[i], set[i], clr[i]);
    end
  end

endmodule

// File: rtl/aud_busy_track.sv
module aud_busy_track import aud_stat_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_en,
  input  logic  tx_en,
  input  logic  cs_en,
  input  logic  usr_en,
  input  logic  rx_lock,
  input  logic  rx_idle,
  input  logic  rx_fe,
  input  logic  tx_fe,
  input  logic  cs_first,
  input  logic  cs_last,
  input  logic  usr_have,
  output busy_t busy
);

  // Named events, visible to waveforms and assertions.
  logic rx_set, rx_clr, tx_stop, cs_set, cs_clr, usr_set, usr_clr;

  assign rx_set  = rx_en & rx_lock;
  assign rx_clr  = rx_idle | (~rx_en & rx_fe);
  assign tx_stop = ~tx_en & tx_fe;
  assign cs_set  = tx_en & cs_en & cs_first;
  assign cs_clr  = cs_last | tx_stop;
  assign usr_set = tx_en & usr_en & usr_have;
  assign usr_clr = ~usr_have | tx_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= '0;
    end else begin
      busy.rx  <= busy_next(busy.rx,  rx_set,  rx_clr,  1'b0);
      busy.tx  <= busy_next(busy.tx,  tx_en,   tx_fe,   1'b1);
      busy.cs  <= busy_next(busy.cs,  cs_set,  cs_clr,  1'b0);
      busy.usr <= busy_next(busy.usr, usr_set, usr_clr, 1'b1);
    end
  end

endmodule

// File: rtl/aud_irq_reg.sv
module aud_irq_reg import aud_stat_pkg::*; #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] en,
  output logic         irq
);

  logic [31:0] flags_x, en_x;
  assign flags_x = 32'(flags);
  assign en_x    = 32'(en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_enabled(flags_x, en_x);
  end

endmodule

// File: rtl/aud_stat_irq_ctrl.sv
module aud_stat_irq_ctrl import aud_stat_pkg::*; #(
  parameter int DW       = 32,
  parameter int N_STICKY = 6,
  parameter int N_ATTN   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [DW-1:0]       wr_data,
  input  logic [N_STICKY-1:0] evt_in,
  input  logic [N_ATTN-1:0]   attn_in,
  input  logic                rx_lock,
  input  logic                rx_idle,
  input  logic                rx_frame_end,
  input  logic                tx_frame_end,
  input  logic                cs_first_load,
  input  logic                cs_last_load,
  input  logic                tu_has_data,
  output logic [DW-1:0]       ctrl_rd,
  output logic [DW-1:0]       stat_rd,
  output logic                irq
);

  localparam int ATTN_LSB   = 16;
  localparam int STICKY_LSB = ATTN_LSB + N_ATTN;
  localparam int BUSY_LSB   = STICKY_LSB + N_STICKY;
  localparam int BUSY_W     = 4;
  localparam int CTRL_HI    = BUSY_LSB + BUSY_W - 1;
  localparam int IRQ_W      = N_STICKY + N_ATTN;

  function automatic logic [DW-1:0] range_mask(input int hi, input int lo);
    logic [DW-1:0] m;
    m = '0;
    for (int b = 0; b < DW; b++) m[b] = (b >= lo) && (b <= hi);
    return m;
  endfunction

  localparam logic [DW-1:0] CTRL_MASK = range_mask(CTRL_HI, ATTN_LSB);

  logic                ctrl_wr, stat_wr;
  logic [DW-1:0]       ctrl_q;
  logic [N_ATTN-1:0]   attn_q;
  logic [N_STICKY-1:0] sticky_q, sticky_set, sticky_clr;
  logic [DW-1:0]       stat_w;
  busy_t               busy;

  assign ctrl_wr    = wr_en & ~wr_sel;
  assign stat_wr    = wr_en &  wr_sel;
  assign sticky_set = evt_in;
  assign sticky_clr = stat_wr ? wr_data[STICKY_LSB +: N_STICKY] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= wr_data & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attn_q <= '0;
    else        attn_q <= attn_in;
  end

  aud_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sticky_set),
    .clr   (sticky_clr),
    .q     (sticky_q)
  );

  aud_busy_track u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (ctrl_q[BUSY_LSB + 3]),
    .tx_en    (ctrl_q[BUSY_LSB + 2]),
    .cs_en    (ctrl_q[BUSY_LSB + 1]),
    .usr_en   (ctrl_q[BUSY_LSB]),
    .rx_lock  (rx_lock),
    .rx_idle  (rx_idle),
    .rx_fe    (rx_frame_end),
    .tx_fe    (tx_frame_end),
    .cs_first (cs_first_load),
    .cs_last  (cs_last_load),
    .usr_have (tu_has_data),
    .busy     (busy)
  );

  always_comb begin
    stat_w = '0;
    stat_w[BUSY_LSB +: BUSY_W]     = busy;
    stat_w[STICKY_LSB +: N_STICKY] = sticky_q;
    stat_w[ATTN_LSB +: N_ATTN]     = attn_q;
  end

  aud_irq_reg #(.W(IRQ_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (stat_w[ATTN_LSB +: IRQ_W]),
    .en    (ctrl_q[ATTN_LSB +: IRQ_W]),
    .irq   (irq)
  );

  assign ctrl_rd = ctrl_q;
  assign stat_rd = stat_w;

endmodule

// File: rtl/aud_stat_irq_ctrl_chk.sv
module aud_stat_irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stat_wr,
  input logic [31:0] wr_data,
  input logic [5:0]  set_vec,
  input logic [3:0]  attn_in,
  input logic        rx_idle,
  input logic        tu_has_data,
  input logic [31:0] ctrl_rd,
  input logic [31:0] stat_rd,
  input logic        irq
);

  // R2: with no event and no write, sticky flags keep their value
  a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_wr && set_vec == 6'd0) |=> (stat_rd[25:20] == $past(stat_rd[25:20])));

  // R3: a write clears every named bit that had no simultaneous event
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((stat_rd[25:20] & $past(wr_data[25:20] & ~set_vec)) == 6'd0));

  // R4: an event always leaves its bit set
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 6'd0) |=> ((stat_rd[25:20] & $past(set_vec)) == $past(set_vec)));

  // R5: attention bits mirror their inputs one clock later
  a_r5_attn_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (stat_rd[19:16] == $past(attn_in)));

  // R6: transmit enable forces transmit busy on the next clock
  a_r6_tx_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[28] |=> stat_rd[28]);

  // R7: an idle stream drops receive busy
  a_r7_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    rx_idle |=> !stat_rd[29]);

  // R9: user busy cannot outlive the user FIFO contents
  a_r9_usr_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !tu_has_data |=> !stat_rd[26]);

  // R10: interrupt line follows the enabled flags one clock later
  a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq == $past(|(stat_rd[25:16] & ctrl_rd[25:16]))));

  // R11: unused bits of both words stay zero
  a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd[31:30] == 2'b00) && (ctrl_rd[15:0] == 16'd0) &&
    (stat_rd[31:30] == 2'b00) && (stat_rd[15:0] == 16'd0));

endmodule

bind aud_stat_irq_ctrl aud_stat_irq_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stat_wr     (stat_wr),
  .wr_data     (wr_data),
  .set_vec     (sticky_set),
  .attn_in     (attn_in),
  .rx_idle     (rx_idle),
  .tu_has_data (tu_has_data),
  .ctrl_rd     (ctrl_rd),
  .stat_rd     (stat_rd),
  .irq         (irq)
);

// File: tb/aud_stat_irq_ctrl_bench.sv
`timescale 1ns/1ps
module aud_stat_irq_ctrl_bench;

  localparam real HALF = 2.5;  // 200 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [5:0]  evt_in = '0;
  logic [3:0]  attn_in = '0;
  logic        rx_lock = 1'b0, rx_idle = 1'b0, rx_frame_end = 1'b0, tx_frame_end = 1'b0;
  logic        cs_first_load = 1'b0, cs_last_load = 1'b0, tu_has_data = 1'b0;
  logic [31:0] ctrl_rd, stat_rd;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] m_ctrl = '0, m_stat = '0;
  logic        m_irq = 1'b0;

  always #(HALF) clk = ~clk;

  aud_stat_irq_ctrl u_aud_stat_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_in(evt_in), .attn_in(attn_in), .rx_lock(rx_lock), .rx_idle(rx_idle),
    .rx_frame_end(rx_frame_end), .tx_frame_end(tx_frame_end),
    .cs_first_load(cs_first_load), .cs_last_load(cs_last_load),
    .tu_has_data(tu_has_data), .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_mask(input logic [31:0] w);
    return w & 32'h3FFF_0000;
  endfunction

  // Reference model of one clock edge, built from the requirements.
  task automatic model_edge();
    logic [31:0] ns, nc;
    logic ni, rxe, txe, cse, ue;
    rxe = m_ctrl[29]; txe = m_ctrl[28]; cse = m_ctrl[27]; ue = m_ctrl[26];
    ns = 32'd0;
    // R7
    if (rx_idle)                   ns[29] = 1'b0;
    else if (rxe && rx_lock)       ns[29] = 1'b1;
    else if (!rxe && rx_frame_end) ns[29] = 1'b0;
    else                           ns[29] = m_stat[29];
    // R6
    if (txe)               ns[28] = 1'b1;
    else if (tx_frame_end) ns[28] = 1'b0;
    else                   ns[28] = m_stat[28];
    // R8
    if (cs_last_load || (!txe && tx_frame_end))  ns[27] = 1'b0;
    else if (txe && cse && cs_first_load)        ns[27] = 1'b1;
    else                                         ns[27] = m_stat[27];
    // R9
    if (txe && ue && tu_has_data)                   ns[26] = 1'b1;
    else if (!tu_has_data || (!txe && tx_frame_end)) ns[26] = 1'b0;
    else                                            ns[26] = m_stat[26];
    // R2, R3, R4
    for (int k = 0; k < 6; k++) begin
      if (evt_in[k])                          ns[20+k] = 1'b1;
      else if (wr_en && wr_sel && wr_data[20+k]) ns[20+k] = 1'b0;
      else                                    ns[20+k] = m_stat[20+k];
    end
    // R5
    ns[19:16] = attn_in;
    // R11
    nc = (wr_en && !wr_sel) ? word_mask(wr_data) : m_ctrl;
    // R10
    ni = |(m_stat[25:16] & m_ctrl[25:16]);
    @(posedge clk);
    m_stat = ns; m_ctrl = nc; m_irq = ni;
    @(negedge clk);
  endtask

  task automatic compare_all();
    chk("R11 ctrl", ctrl_rd, m_ctrl);
    chk("R7 rx busy", {31'd0, stat_rd[29]}, {31'd0, m_stat[29]});
    chk("R6 tx busy", {31'd0, stat_rd[28]}, {31'd0, m_stat[28]});
    chk("R8 cs busy", {31'd0, stat_rd[27]}, {31'd0, m_stat[27]});
    chk("R9 user busy", {31'd0, stat_rd[26]}, {31'd0, m_stat[26]});
    chk("R2 R3 R4 sticky", {26'd0, stat_rd[25:20]}, {26'd0, m_stat[25:20]});
    chk("R5 attention", {28'd0, stat_rd[19:16]}, {28'd0, m_stat[19:16]});
    chk("R11 status unused", stat_rd & ~32'h3FFF_0000, 32'd0);
    chk("R10 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle_inputs();
    wr_en = 0; wr_sel = 0; wr_data = '0; evt_in = '0;
    rx_lock = 0; rx_idle = 0; rx_frame_end = 0; tx_frame_end = 0;
    cs_first_load = 0; cs_last_load = 0;
  endtask

  task automatic step();
    model_edge();
    compare_all();
    idle_inputs();
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ctrl reset", ctrl_rd, 32'd0);
    chk("R1 stat reset", stat_rd, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;

    // R11: control write masks unused bits
    wr_en = 1; wr_sel = 0; wr_data = 32'hFFFF_FFFF; tu_has_data = 1;
    step();
    chk("R11 ctrl mask", ctrl_rd, 32'h3FFF_0000);
    step();
    chk("R6 tx busy after enable", {31'd0, stat_rd[28]}, 32'd1);

    // R2: set all sticky bits
    evt_in = 6'h3F;
    step();
    chk("R2 all sticky set", {26'd0, stat_rd[25:20]}, 32'h3F);
    step();
    chk("R10 irq with enabled flags", {31'd0, irq}, 32'd1);

    // R4: clear all while bit 20 event arrives
    wr_en = 1; wr_sel = 1; wr_data = 32'hFFFF_FFFF; evt_in = 6'h01;
    step();
    chk("R4 event beats clear", {26'd0, stat_rd[25:20]}, 32'h01);

    // R5: status write leaves attention bits alone
    attn_in = 4'hA; step();
    wr_en = 1; wr_sel = 1; wr_data = 32'h000F_0000;
    step();
    chk("R5 attention ignores writes", {28'd0, stat_rd[19:16]}, 32'hA);

    // R6: disable transmit, busy held until frame end
    wr_en = 1; wr_sel = 0; wr_data = 32'h0000_0000;
    step(); step(); step();
    chk("R6 tx busy held", {31'd0, stat_rd[28]}, 32'd1);
    tx_frame_end = 1; step();
    chk("R6 tx busy falls", {31'd0, stat_rd[28]}, 32'd0);

    // R7: receive lock then idle
    wr_en = 1; wr_sel = 0; wr_data = 32'h2000_0000; step();
    rx_lock = 1; step();
    chk("R7 rx busy on lock", {31'd0, stat_rd[29]}, 32'd1);
    rx_idle = 1; rx_lock = 1; step();
    chk("R7 idle wins", {31'd0, stat_rd[29]}, 32'd0);

    // R8: channel-status load sequence
    wr_en = 1; wr_sel = 0; wr_data = 32'h1800_0000; step();
    cs_first_load = 1; step();
    chk("R8 cs busy set", {31'd0, stat_rd[27]}, 32'd1);
    cs_last_load = 1; step();
    chk("R8 cs busy cleared", {31'd0, stat_rd[27]}, 32'd0);

    // R9: user busy drops when FIFO empties
    wr_en = 1; wr_sel = 0; wr_data = 32'h1400_0000; step(); step();
    chk("R9 user busy set", {31'd0, stat_rd[26]}, 32'd1);
    tu_has_data = 0; step();
    chk("R9 user busy cleared", {31'd0, stat_rd[26]}, 32'd0);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      wr_en         = ($urandom % 6) == 0;
      wr_sel        = $urandom % 2;
      wr_data       = $urandom;
      for (int k = 0; k < 6; k++) evt_in[k] = ($urandom % 16) == 0;
      attn_in       = $urandom;
      rx_lock       = ($urandom % 8) == 0;
      rx_idle       = ($urandom % 40) == 0;
      rx_frame_end  = ($urandom % 10) == 0;
      tx_frame_end  = ($urandom % 10) == 0;
      cs_first_load = ($urandom % 12) == 0;
      cs_last_load  = ($urandom % 20) == 0;
      if (($urandom % 5) == 0) tu_has_data = ~tu_has_data;
      step();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule